// File: doc/BRIEF.md
# Blocked Matrix-Multiply Tile Sequencer

This block generates addresses for a blocked multiply of two square matrices, C += A x B. All three matrices are stored row-major in an external memory. At start it samples the matrix dimension N and the tile edge NB. It then walks the tile loops and the element loops inside each tile. For every multiply-accumulate term it emits three element indices: one into A, one into B and one into C. Two flags go with each term and mark the opening and closing term of each C element's sum, so a downstream accumulator can run across tile boundaries. Memory access and arithmetic live elsewhere.

Terms leave on a valid/ready stream. A term counts as transferred in a cycle where `out_valid_o` and `out_ready_i` are both high at the rising clock edge. While valid is high and ready is low, the term on the outputs stays unchanged. The stream never drops valid in the middle of a run. The consumer may hold ready high or low for any number of cycles. `start_i`, `done_o` and `err_o` are plain level or pulse signals.

The supported matrix sizes are the powers of two from 2^LOG2_NMIN to 2^LOG2_NMAX, which is 64 to 1024 by default. The size is chosen at run time, so a new size needs no new hardware. All indices are computed with shifts by log2(N); the block has no multipliers.

Top module: `bmm_tile_seq`

## Requirements
- R1: A start with an unsupported configuration raises `err_o` on the next cycle. A configuration is unsupported when N is not a power of two in [2^LOG2_NMIN, 2^LOG2_NMAX], or NB is zero, or NB is not a power of two, or NB is larger than N. While `err_o` is high, `out_valid_o` and `done_o` stay low. The next start with a supported configuration clears `err_o`.
- R2: A run issues exactly N^3 terms without gaps. The loops nest in this order, outermost first: column tile jt, row tile it, reduction tile kt (each stepping by NB), then inner column jj, inner row ii, inner reduction kk (each from 0 to NB-1).
- R3: Each term carries three 0-based row-major indices, where element (r,c) is at r*N + c. A index = (it+ii)*N + (kt+kk). B index = (kt+kk)*N + (jt+jj). C index = (it+ii)*N + (jt+jj).
- R4: `first_o` is high exactly on the terms where kt = 0 and kk = 0.
- R5: `last_o` is high exactly on the terms where kt = N-NB and kk = NB-1.
- R6: While `out_valid_o` is high and `out_ready_i` is low, all term outputs keep their values into the next cycle.
- R7: The cycle after the final term is transferred, `done_o` is high for exactly one cycle and `out_valid_o` is low.
- R8: N and NB are sampled only when the block accepts a start. A start, or a change of N or NB, during a run has no effect on the terms issued.
- R9: After reset, `out_valid_o`, `done_o` and `err_o` are low.
- R10: The first term of a run is valid in the cycle after the start is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a run; ignored while a run is in progress |
| cfg_n_i | input | LOG2_NMAX+1 | Matrix dimension N |
| cfg_nb_i | input | LOG2_NMAX+1 | Tile edge NB |
| out_valid_o | output | 1 | A term is on the outputs |
| out_ready_i | input | 1 | Consumer accepts the term |
| a_idx_o | output | 2*LOG2_NMAX | Element index into A |
| b_idx_o | output | 2*LOG2_NMAX | Element index into B |
| c_idx_o | output | 2*LOG2_NMAX | Element index into C |
| first_o | output | 1 | Opening term of this C element's sum |
| last_o | output | 1 | Closing term of this C element's sum |
| done_o | output | 1 | One-cycle pulse after the final transfer |
| err_o | output | 1 | The last start had an unsupported configuration |

## Verification
Two situations are hard to reach from the ports. One is a start pulse, together with changed configuration inputs, arriving partway through a run. The other is back-pressure that lands on the carry boundaries where several loop counters wrap in the same transfer. The bench reaches both by instantiating the block with small matrix sizes, so whole runs fit in a few thousand cycles. Each run is compared term by term against a nested-loop model in the bench while ready follows steady, alternating and one-in-three-stalled patterns. One run injects a start with a different N and NB a few terms in, and the term sequence must remain unchanged. The tile edges include NB = 1 and NB = N, where the first and last flags fall on the same tile.

// File: rtl/bmm_pkg.sv
package bmm_pkg;
  // Loop levels, innermost first; the carry ripples upward through them.
  localparam int LV_KK  = 0;
  localparam int LV_II  = 1;
  localparam int LV_JJ  = 2;
  localparam int LV_KT  = 3;
  localparam int LV_IT  = 4;
  localparam int LV_JT  = 5;
  localparam int NUM_LV = 6;
  // Levels at or above this index walk tiles and step by NB.
  localparam int FIRST_TILE_LV = LV_KT;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FAIL = 2'd2
  } seq_state_t;
endpackage

// File: rtl/bmm_cfg_check.sv
module bmm_cfg_check #(
  parameter int LOG2_NMIN = 6,
  parameter int LOG2_NMAX = 10,
  localparam int NW = LOG2_NMAX + 1,
  localparam int CW = LOG2_NMAX,
  localparam int LW = $clog2(NW)
) (
  input  logic [NW-1:0] n_i,
  input  logic [NW-1:0] nb_i,
  output logic          ok_o,
  output logic [LW-1:0] log2n_o,
  output logic [CW-1:0] nb_m1_o,
  output logic [CW-1:0] n_m_nb_o
);
  logic n_pow2, nb_pow2, n_big_enough, nb_fits;

  always_comb begin
    log2n_o = '0;
    for (int b = 0; b < NW; b++) begin
      if (n_i[b]) log2n_o = LW'(b);
    end
  end

  assign n_pow2       = (n_i != '0) && ((n_i & (n_i - 1'b1)) == '0);
  assign nb_pow2      = (nb_i != '0) && ((nb_i & (nb_i - 1'b1)) == '0);
  assign n_big_enough = (32'(log2n_o) >= LOG2_NMIN);
  assign nb_fits      = (nb_i <= n_i);
  assign ok_o         = n_pow2 && nb_pow2 && n_big_enough && nb_fits;

  assign nb_m1_o  = CW'(nb_i - 1'b1);
  assign n_m_nb_o = CW'(n_i - nb_i);
endmodule

// File: rtl/bmm_level_ctr.sv
module bmm_level_ctr #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          adv_i,
  input  logic [CW-1:0] step_i,
  input  logic [CW-1:0] limit_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);
  assign wrap_o = (cnt_o == limit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (adv_i)  cnt_o <= wrap_o ? '0 : cnt_o + step_i;
  end
endmodule

// File: rtl/bmm_addr_gen.sv
module bmm_addr_gen #(
  parameter int CW = 10,
  localparam int AW = 2 * CW,
  localparam int LW = $clog2(CW + 1)
) (
  input  logic [CW-1:0] jt_i,
  input  logic [CW-1:0] it_i,
  input  logic [CW-1:0] kt_i,
  input  logic [CW-1:0] jj_i,
  input  logic [CW-1:0] ii_i,
  input  logic [CW-1:0] kk_i,
  input  logic [LW-1:0] log2n_i,
  input  logic [CW-1:0] nb_m1_i,
  input  logic [CW-1:0] n_m_nb_i,
  output logic [AW-1:0] a_idx_o,
  output logic [AW-1:0] b_idx_o,
  output logic [AW-1:0] c_idx_o,
  output logic          first_o,
  output logic          last_o
);
  logic [CW-1:0] row, col_k, col_j;
  logic [AW-1:0] row_base, k_base;

  // Tile origins and inner offsets never carry past N-1.
  assign row   = it_i + ii_i;
  assign col_k = kt_i + kk_i;
  assign col_j = jt_i + jj_i;

  assign row_base = {{(AW-CW){1'b0}}, row}   << log2n_i;
  assign k_base   = {{(AW-CW){1'b0}}, col_k} << log2n_i;

  assign a_idx_o = row_base + {{(AW-CW){1'b0}}, col_k};
  assign b_idx_o = k_base   + {{(AW-CW){1'b0}}, col_j};
  assign c_idx_o = row_base + {{(AW-CW){1'b0}}, col_j};

  assign first_o = (kt_i == '0) && (kk_i == '0);
  assign last_o  = (kt_i == n_m_nb_i) && (kk_i == nb_m1_i);
endmodule

// File: rtl/bmm_tile_seq.sv
module bmm_tile_seq
  import bmm_pkg::*;
#(
  parameter int LOG2_NMIN = 6,
  parameter int LOG2_NMAX = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [LOG2_NMAX:0]       cfg_n_i,
  input  logic [LOG2_NMAX:0]       cfg_nb_i,
  output logic                     out_valid_o,
  input  logic                     out_ready_i,
  output logic [2*LOG2_NMAX-1:0]   a_idx_o,
  output logic [2*LOG2_NMAX-1:0]   b_idx_o,
  output logic [2*LOG2_NMAX-1:0]   c_idx_o,
  output logic                     first_o,
  output logic                     last_o,
  output logic                     done_o,
  output logic                     err_o
);
  localparam int CW = LOG2_NMAX;
  localparam int LW = $clog2(LOG2_NMAX + 1);

  seq_state_t    state_q;
  logic          cfg_ok;
  logic [LW-1:0] cfg_log2n;
  logic [CW-1:0] cfg_nb_m1, cfg_n_m_nb;
  logic [LW-1:0] log2n_q;
  logic [CW-1:0] nb_m1_q, n_m_nb_q, nb_step;
  logic          accept, fire, finish;

  logic [CW-1:0] lv_cnt  [NUM_LV];
  logic          lv_wrap [NUM_LV];
  logic          lv_adv  [NUM_LV+1];

  bmm_cfg_check #(.LOG2_NMIN(LOG2_NMIN), .LOG2_NMAX(LOG2_NMAX)) u_cfg (
    .n_i      (cfg_n_i),
    .nb_i     (cfg_nb_i),
    .ok_o     (cfg_ok),
    .log2n_o  (cfg_log2n),
    .nb_m1_o  (cfg_nb_m1),
    .n_m_nb_o (cfg_n_m_nb)
  );

  assign accept      = start_i && (state_q != ST_RUN);
  assign out_valid_o = (state_q == ST_RUN);
  assign err_o       = (state_q == ST_FAIL);
  assign fire        = out_valid_o && out_ready_i;
  assign nb_step     = nb_m1_q + 1'b1;

  // Configuration is captured only when a start is accepted.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      log2n_q  <= '0;
      nb_m1_q  <= '0;
      n_m_nb_q <= '0;
    end else if (accept && cfg_ok) begin
      log2n_q  <= cfg_log2n;
      nb_m1_q  <= cfg_nb_m1;
      n_m_nb_q <= cfg_n_m_nb;
    end
  end

  // Carry chain through the six nested loop levels.
  assign lv_adv[0] = fire;
  generate
    for (genvar g = 0; g < NUM_LV; g++) begin : g_lv
      logic [CW-1:0] step_w, limit_w;
      if (g >= FIRST_TILE_LV) begin : g_tile
        assign step_w  = nb_step;
        assign limit_w = n_m_nb_q;
      end else begin : g_inner
        assign step_w  = CW'(1);
        assign limit_w = nb_m1_q;
      end
      bmm_level_ctr #(.CW(CW)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (accept),
        .adv_i   (lv_adv[g]),
        .step_i  (step_w),
        .limit_i (limit_w),
        .cnt_o   (lv_cnt[g]),
        .wrap_o  (lv_wrap[g])
      );
      assign lv_adv[g+1] = lv_adv[g] && lv_wrap[g];
    end
  endgenerate

  assign finish = lv_adv[NUM_LV];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_RUN: begin
          if (finish) begin
            state_q <= ST_IDLE;
            done_o  <= 1'b1;
          end
        end
        default: begin
          if (accept) state_q <= cfg_ok ? ST_RUN : ST_FAIL;
        end
      endcase
    end
  end

  bmm_addr_gen #(.CW(CW)) u_addr (
    .jt_i     (lv_cnt[LV_JT]),
    .it_i     (lv_cnt[LV_IT]),
    .kt_i     (lv_cnt[LV_KT]),
    .jj_i     (lv_cnt[LV_JJ]),
    .ii_i     (lv_cnt[LV_II]),
    .kk_i     (lv_cnt[LV_KK]),
    .log2n_i  (log2n_q),
    .nb_m1_i  (nb_m1_q),
    .n_m_nb_i (n_m_nb_q),
    .a_idx_o  (a_idx_o),
    .b_idx_o  (b_idx_o),
    .c_idx_o  (c_idx_o),
    .first_o  (first_o),
    .last_o   (last_o)
  );
endmodule

// File: rtl/bmm_tile_seq_chk.sv
module bmm_tile_seq_chk #(
  parameter int LOG2_NMAX = 10
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   out_valid_o,
  input logic                   out_ready_i,
  input logic [2*LOG2_NMAX-1:0] a_idx_o,
  input logic [2*LOG2_NMAX-1:0] b_idx_o,
  input logic [2*LOG2_NMAX-1:0] c_idx_o,
  input logic                   first_o,
  input logic                   last_o,
  input logic                   done_o,
  input logic                   err_o
);
  p_hold_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(a_idx_o) &&
      $stable(b_idx_o) && $stable(c_idx_o) && $stable(first_o) && $stable(last_o)));

  p_no_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_ready_i && !last_o) |=> out_valid_o);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(out_valid_o && out_ready_i && last_o) && !out_valid_o));

  p_err_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!out_valid_o && !done_o));
endmodule

bind bmm_tile_seq bmm_tile_seq_chk #(.LOG2_NMAX(LOG2_NMAX)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .a_idx_o     (a_idx_o),
  .b_idx_o     (b_idx_o),
  .c_idx_o     (c_idx_o),
  .first_o     (first_o),
  .last_o      (last_o),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/bmm_tile_seq_tb.sv
module bmm_tile_seq_tb_top;
  localparam int LNMIN = 2;
  localparam int LNMAX = 4;
  localparam int NW = LNMAX + 1;
  localparam int AW = 2 * LNMAX;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [NW-1:0] cfg_n_i = '0;
  logic [NW-1:0] cfg_nb_i = '0;
  logic          out_valid_o;
  logic          out_ready_i = 1'b0;
  logic [AW-1:0] a_idx_o, b_idx_o, c_idx_o;
  logic          first_o, last_o, done_o, err_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bmm_tile_seq #(.LOG2_NMIN(LNMIN), .LOG2_NMAX(LNMAX)) dut_i (
    .clk (clk), .rst_n (rst_n), .start_i (start_i),
    .cfg_n_i (cfg_n_i), .cfg_nb_i (cfg_nb_i),
    .out_valid_o (out_valid_o), .out_ready_i (out_ready_i),
    .a_idx_o (a_idx_o), .b_idx_o (b_idx_o), .c_idx_o (c_idx_o),
    .first_o (first_o), .last_o (last_o),
    .done_o (done_o), .err_o (err_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic bit ready_pat(input int mode);
    if (mode == 0) return 1'b1;
    if (mode == 1) return cyc[0];
    return (cyc % 3) != 1;
  endfunction

  // R9: reset state
  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid_o == 1'b0, "R9 valid", out_valid_o, 0);
    check(done_o == 1'b0, "R9 done", done_o, 0);
    check(err_o == 1'b0, "R9 err", err_o, 0);
  endtask

  // R1: unsupported configuration
  task automatic t_bad_cfg(input int n, input int nb);
    @(negedge clk);
    cfg_n_i = NW'(n); cfg_nb_i = NW'(nb); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(err_o == 1'b1, "R1 err raised", err_o, 1);
    for (int w = 0; w < 4; w++) begin
      check(!out_valid_o && !done_o, "R1 quiet", out_valid_o, 0);
      @(negedge clk);
    end
  endtask

  // R2..R8, R10: full run compared with a nested-loop model
  task automatic t_run(input int n, input int nb, input int mode, input bit disturb);
    int idx = 0;
    @(negedge clk);
    out_ready_i = 1'b0;
    cfg_n_i = NW'(n); cfg_nb_i = NW'(nb); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(out_valid_o == 1'b1, "R10 valid after start", out_valid_o, 1);
    check(err_o == 1'b0, "R1 err cleared", err_o, 0);
    for (int jt = 0; jt < n; jt += nb)
     for (int it = 0; it < n; it += nb)
      for (int kt = 0; kt < n; kt += nb)
       for (int jj = 0; jj < nb; jj++)
        for (int ii = 0; ii < nb; ii++)
         for (int kk = 0; kk < nb; kk++) begin
           int ea, eb, ec, waits;
           bit ef, el, got;
           ea = (it + ii) * n + (kt + kk);
           eb = (kt + kk) * n + (jt + jj);
           ec = (it + ii) * n + (jt + jj);
           ef = (kt == 0) && (kk == 0);
           el = (kt == n - nb) && (kk == nb - 1);
           if (disturb && idx == 5) begin
             // R8: start with other settings mid-run must be ignored
             out_ready_i = 1'b0;
             cfg_n_i = NW'(8); cfg_nb_i = NW'(1); start_i = 1'b1;
             @(negedge clk);
             start_i = 1'b0;
           end
           waits = 0;
           got = 1'b0;
           while (!got) begin
             logic [AW-1:0] sa, sb, sc;
             bit sf, sl, stalled;
             out_ready_i = ready_pat(mode);
             stalled = 1'b0;
             if (out_valid_o && out_ready_i) begin
               got = 1'b1;
               check(a_idx_o == AW'(ea), "R3 A index", int'(a_idx_o), ea);
               check(b_idx_o == AW'(eb), "R3 B index", int'(b_idx_o), eb);
               check(c_idx_o == AW'(ec), "R2 R3 C index", int'(c_idx_o), ec);
               check(first_o == ef, "R4 first", first_o, ef);
               check(last_o == el, "R5 last", last_o, el);
             end else if (out_valid_o) begin
               sa = a_idx_o; sb = b_idx_o; sc = c_idx_o; sf = first_o; sl = last_o;
               stalled = 1'b1;
             end else begin
               check(1'b0, "R2 valid gap", out_valid_o, 1);
             end
             @(negedge clk);
             if (stalled)
               check(out_valid_o && a_idx_o == sa && b_idx_o == sb && c_idx_o == sc &&
                     first_o == sf && last_o == sl, "R6 hold", int'(a_idx_o), int'(sa));
             waits++;
             if (waits > 50) begin
               check(1'b0, "R2 term stuck", idx, -1);
               return;
             end
           end
           idx++;
         end
    out_ready_i = 1'b0;
    check(idx == n * n * n, "R2 term count", idx, n * n * n);
    check(done_o == 1'b1, "R7 done pulse", done_o, 1);
    check(out_valid_o == 1'b0, "R7 valid low at done", out_valid_o, 0);
    @(negedge clk);
    check(done_o == 1'b0, "R7 done one cycle", done_o, 0);
    check(out_valid_o == 1'b0, "R7 stays idle", out_valid_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_run(4, 2, 0, 1'b0);
    t_run(8, 2, 1, 1'b0);
    t_bad_cfg(2, 1);    // R1: N below minimum
    t_bad_cfg(12, 4);   // R1: N not a power of two
    t_bad_cfg(8, 3);    // R1: NB not a power of two
    t_bad_cfg(8, 16);   // R1: NB larger than N
    t_bad_cfg(16, 0);   // R1: NB zero
    t_run(4, 4, 2, 1'b0);
    t_run(8, 1, 2, 1'b0);
    t_run(16, 4, 2, 1'b0);
    t_run(16, 16, 1, 1'b0);
    t_run(8, 4, 2, 1'b1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule